// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when a volatile memory array is copied into its nonvolatile shadow (a store) and when the shadow is copied back (a recall). It watches two digital supply-status flags, one for the supply being under the switch threshold and one for it being under the reset threshold. It also reads an open-drain request/busy line that any party may pull low, receives a pulse for each write on the memory port, and has a strap that enables or disables automatic store on power loss. From these inputs it drives a pull-down enable for the shared line, a write-block flag, an array-disable flag, and one-cycle start pulses for the store and recall copy engines.

A store happens only when the array holds data written since the last nonvolatile cycle. An external request first opens a grace window, so that in-flight accesses can finish. After the store, or after a request that found nothing to store, the array stays disabled until the shared line is seen high again. An automatic attempt on power loss briefly pulls the line low. If the line still reads high, an external driver is overriding it, and the attempt is dropped. Recall runs when the supply comes back above the switch level, and only when the supply earlier dropped below the reset level. All durations are parameters in clock cycles. The line and both supply flags pass through two-flop synchronisers.

Top module: `nvseq_top`

## Requirements
- R1: A write pulse accepted while `wr_block_o` is low marks the array dirty. A store, whether requested automatically or on the line, starts (`store_start_o`) only if the array is dirty; otherwise no store occurs.
- R2: When the line reads low while the supply is above the switch level, `wr_block_o` goes high and the array stays enabled (`sram_off_o` low) for a grace window of GRACE_CYC cycles. Only then can the store start. A write pulse given after the line fell is ignored and does not mark the array dirty. Writes are accepted again once the line is high and the sequencer is idle.
- R3: During a store, `line_pull_o` is high for exactly STORE_CYC cycles, counted from the `store_start_o` cycle, and then drops.
- R4: After a store, and after a line request that found the array clean, `sram_off_o` stays high with `line_pull_o` low until the line reads high again.
- R5: A recall starts with `recall_start_o` when the supply flag shows the supply above the switch level. `sram_off_o` is then high for exactly RECALL_CYC cycles, counted from that pulse.
- R6: A recall runs only if the below-reset flag was seen since the last recall; reset of the block counts as such an event. A drop below the switch level alone causes no recall.
- R7: With automatic mode on, a rising below-switch flag drives `line_pull_o` high for PULSE_CYC cycles. If the array is clean, the line is then released and no store runs. If the array is dirty, the store follows directly, so `line_pull_o` is high for PULSE_CYC+STORE_CYC cycles in total.
- R8: During an automatic pulse, if the line still reads high once the synchroniser has settled (from the fourth pulse cycle), the pull is removed before PULSE_CYC cycles have passed and no store runs.
- R9: While the supply flag shows the supply below the switch level, `wr_block_o` is high and a low on the line starts no store.
- R10: With automatic mode off (`auto_en_i` low), a falling supply never drives `line_pull_o` and starts no store.
- R11: The dirty mark is cleared when a store or a recall completes. A request arriving while a store or recall is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_switch_i | input | 1 | Supply is under the switch threshold (asynchronous) |
| below_reset_i | input | 1 | Supply is under the reset threshold (asynchronous) |
| req_line_i | input | 1 | Level read back from the open-drain request/busy line (asynchronous) |
| wr_pulse_i | input | 1 | One pulse per write on the memory port |
| auto_en_i | input | 1 | 1 = automatic store on power loss, 0 = inhibit |
| line_pull_o | output | 1 | Enable for the pull-down on the request/busy line |
| wr_block_o | output | 1 | New writes to the array are refused |
| sram_off_o | output | 1 | All array accesses are disabled |
| store_start_o | output | 1 | One-cycle start pulse for the store engine |
| recall_start_o | output | 1 | One-cycle start pulse for the recall engine |

## Verification
If the dirty mark is wrong, the fault shows up at the next request. A missing store, or a spurious `store_start_o`, appears within the grace window or the automatic pulse, so within about ten cycles. A wrong state or timer value shows up as a `line_pull_o` or `sram_off_o` interval that is off by one or more cycles, and it is seen when that interval ends. A lockout that does not hold, or a write block that is missing, shows up on `sram_off_o` and `wr_block_o` within two or three cycles of the line or supply change.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RECALL = 3'd1,
    ST_GRACE  = 3'd2,
    ST_AUTO   = 3'd3,
    ST_STORE  = 3'd4,
    ST_LOCK   = 3'd5
  } nv_state_e;
endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pulse_i,
  input  logic wr_block_i,
  input  logic below_reset_i,
  input  logic store_done_i,
  input  logic recall_done_i,
  output logic dirty_o,
  output logic pend_o
);
  logic dirty_q, dirty_d, dirty_en;
  logic pend_q, pend_d, pend_en;

  always_comb begin
    dirty_en = store_done_i || recall_done_i || (wr_pulse_i && !wr_block_i);
    dirty_d  = !(store_done_i || recall_done_i);
    pend_en  = below_reset_i || recall_done_i;
    pend_d   = below_reset_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      if (dirty_en) dirty_q <= dirty_d;
      if (pend_en)  pend_q  <= pend_d;
    end
  end

  assign dirty_o = dirty_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
#(
  parameter int GRACE_CYC  = 8,
  parameter int PULSE_CYC  = 8,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 40,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          below_s_i,
  input  logic          line_s_i,
  input  logic          auto_en_i,
  input  logic          dirty_i,
  input  logic          pend_i,
  input  logic [CW-1:0] t_cnt_i,
  input  logic          t_zero_i,
  output logic          t_load_o,
  output logic [CW-1:0] t_val_o,
  output nv_state_e     state_o,
  output logic          store_start_o,
  output logic          recall_start_o,
  output logic          store_done_o,
  output logic          recall_done_o
);
  localparam logic [CW-1:0] GRACE_LD  = CW'(GRACE_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] STORE_LD  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RECALL_LD = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] ABORT_AT  = CW'(PULSE_CYC - 4);

  nv_state_e state_q, state_d;
  logic      below_prev_q;
  logic      below_rise;
  logic      sstart_q, rstart_q;

  assign below_rise = below_s_i && !below_prev_q;

  always_comb begin
    state_d       = state_q;
    t_load_o      = 1'b0;
    t_val_o       = '0;
    store_done_o  = 1'b0;
    recall_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_i && !below_s_i) begin
          state_d  = ST_RECALL;
          t_load_o = 1'b1;
          t_val_o  = RECALL_LD;
        end else if (auto_en_i && below_rise) begin
          state_d  = ST_AUTO;
          t_load_o = 1'b1;
          t_val_o  = PULSE_LD;
        end else if (!line_s_i && !below_s_i) begin
          state_d  = ST_GRACE;
          t_load_o = 1'b1;
          t_val_o  = GRACE_LD;
        end
      end
      ST_RECALL: begin
        if (t_zero_i) begin
          state_d       = ST_IDLE;
          recall_done_o = 1'b1;
        end
      end
      ST_GRACE: begin
        if (t_zero_i) begin
          if (dirty_i) begin
            state_d  = ST_STORE;
            t_load_o = 1'b1;
            t_val_o  = STORE_LD;
          end else begin
            state_d = ST_LOCK;
          end
        end
      end
      ST_AUTO: begin
        if (line_s_i && (t_cnt_i <= ABORT_AT)) begin
          state_d = ST_IDLE;
        end else if (t_zero_i) begin
          if (dirty_i) begin
            state_d  = ST_STORE;
            t_load_o = 1'b1;
            t_val_o  = STORE_LD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_STORE: begin
        if (t_zero_i) begin
          state_d      = ST_LOCK;
          store_done_o = 1'b1;
        end
      end
      ST_LOCK: begin
        if (line_s_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      below_prev_q <= 1'b1;
      sstart_q     <= 1'b0;
      rstart_q     <= 1'b0;
    end else begin
      state_q      <= state_d;
      below_prev_q <= below_s_i;
      sstart_q     <= (state_d == ST_STORE)  && (state_q != ST_STORE);
      rstart_q     <= (state_d == ST_RECALL) && (state_q != ST_RECALL);
    end
  end

  assign state_o        = state_q;
  assign store_start_o  = sstart_q;
  assign recall_start_o = rstart_q;
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int GRACE_CYC  = 8,
  parameter int PULSE_CYC  = 8,
  parameter int STORE_CYC  = 64,
  parameter int RECALL_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_switch_i,
  input  logic below_reset_i,
  input  logic req_line_i,
  input  logic wr_pulse_i,
  input  logic auto_en_i,
  output logic line_pull_o,
  output logic wr_block_o,
  output logic sram_off_o,
  output logic store_start_o,
  output logic recall_start_o
);
  localparam int MAX_A   = (GRACE_CYC > PULSE_CYC) ? GRACE_CYC : PULSE_CYC;
  localparam int MAX_B   = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [2:0]    sync_q;
  logic          below_s, reset_s, line_s;
  logic          dirty_q, pend_q;
  logic          t_load, t_zero;
  logic [CW-1:0] t_val, t_cnt;
  logic          store_done, recall_done;
  nv_state_e     state;

  nvseq_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({req_line_i, below_reset_i, below_switch_i}),
    .q_o   (sync_q)
  );
  assign below_s = sync_q[0];
  assign reset_s = sync_q[1];
  assign line_s  = sync_q[2];

  nvseq_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (t_load),
    .load_val_i (t_val),
    .cnt_o      (t_cnt),
    .zero_o     (t_zero)
  );

  nvseq_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_pulse_i    (wr_pulse_i),
    .wr_block_i    (wr_block_o),
    .below_reset_i (reset_s),
    .store_done_i  (store_done),
    .recall_done_i (recall_done),
    .dirty_o       (dirty_q),
    .pend_o        (pend_q)
  );

  nvseq_fsm #(
    .GRACE_CYC  (GRACE_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .below_s_i      (below_s),
    .line_s_i       (line_s),
    .auto_en_i      (auto_en_i),
    .dirty_i        (dirty_q),
    .pend_i         (pend_q),
    .t_cnt_i        (t_cnt),
    .t_zero_i       (t_zero),
    .t_load_o       (t_load),
    .t_val_o        (t_val),
    .state_o        (state),
    .store_start_o  (store_start_o),
    .recall_start_o (recall_start_o),
    .store_done_o   (store_done),
    .recall_done_o  (recall_done)
  );

  assign line_pull_o = (state == ST_AUTO) || (state == ST_STORE);
  assign sram_off_o  = (state == ST_RECALL) || (state == ST_STORE) || (state == ST_LOCK);
  assign wr_block_o  = below_s || !line_s || (state != ST_IDLE);
endmodule

// File: rtl/nvseq_chk.sv
module nvseq_chk
  import nvseq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      auto_en_i,
  input logic      line_pull_o,
  input logic      wr_block_o,
  input logic      sram_off_o,
  input logic      store_start_o,
  input logic      recall_start_o,
  input logic      dirty_q,
  input logic      pend_q,
  input nv_state_e state
);
  p_store_dirty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |-> dirty_q);

  p_recall_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start_o |-> $past(pend_q));

  p_lock_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_STORE && state == ST_LOCK) |-> (sram_off_o && !line_pull_o));

  p_one_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_start_o, recall_start_o}));

  p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_pull_o) && !auto_en_i && $past(!auto_en_i)) |-> store_start_o);

  p_off_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_off_o |-> wr_block_o);
endmodule

bind nvseq_top nvseq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .auto_en_i      (auto_en_i),
  .line_pull_o    (line_pull_o),
  .wr_block_o     (wr_block_o),
  .sram_off_o     (sram_off_o),
  .store_start_o  (store_start_o),
  .recall_start_o (recall_start_o),
  .dirty_q        (dirty_q),
  .pend_q         (pend_q),
  .state          (state)
);

// File: tb/nvseq_top_test.sv
module nvseq_top_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  GRACE  = 8;
  localparam int  PULSE  = 8;
  localparam int  STORE  = 64;
  localparam int  RECALL = 40;

  typedef struct {
    int    kind;
    int    len;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic below_sw, below_rst, wr, auto_en;
  logic ext_low, ext_high;
  logic line;
  logic line_pull, wr_block, sram_off, sstart, rstart;

  int checks = 0;
  int failures = 0;
  exp_t exp_q[$];

  int mon_act = 0;
  int mon_kind = 0;
  int mon_len = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = ext_high ? 1'b1 : !(line_pull || ext_low);

  nvseq_top #(
    .GRACE_CYC (GRACE), .PULSE_CYC (PULSE),
    .STORE_CYC (STORE), .RECALL_CYC (RECALL)
  ) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .below_switch_i (below_sw),
    .below_reset_i  (below_rst),
    .req_line_i     (line),
    .wr_pulse_i     (wr),
    .auto_en_i      (auto_en),
    .line_pull_o    (line_pull),
    .wr_block_o     (wr_block),
    .sram_off_o     (sram_off),
    .store_start_o  (sstart),
    .recall_start_o (rstart)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic expect_ev(input int kind, input int len, input string tag);
    exp_t e;
    e.kind = kind; e.len = len; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && mon_act == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_write();
    @(negedge clk) wr = 1'b1;
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic count_pull(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (line_pull) cnt++;
    end
  endtask

  task automatic close_event();
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "spurious start (R1/R6)", mon_kind, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == mon_kind, {e.tag, " kind"}, mon_kind, e.kind);
      chk(e.len == mon_len, {e.tag, " length"}, mon_len, e.len);
    end
    mon_act = 0;
  endtask

  // monitor: kind 1 = store (counts line_pull cycles), 2 = recall (counts sram_off cycles)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mon_act != 0) begin
        if ((mon_kind == 1 && line_pull) || (mon_kind == 2 && sram_off)) mon_len++;
        else close_event();
      end
      if (sstart) begin mon_act = 1; mon_kind = 1; mon_len = 1; end
      if (rstart) begin mon_act = 1; mon_kind = 2; mon_len = 1; end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; below_sw = 1'b1; below_rst = 1'b1; wr = 1'b0;
    auto_en = 1'b1; ext_low = 1'b0; ext_high = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state, supply still low
    chk(line_pull == 1'b0 && sstart == 1'b0 && rstart == 1'b0, "R7 reset no pull", line_pull, 0);
    chk(wr_block == 1'b1 && sram_off == 1'b0, "R9 reset write block", wr_block, 1);

    // R5/R6: power-up recall
    expect_ev(2, RECALL, "R5 power-up recall");
    below_rst = 1'b0; below_sw = 1'b0;
    repeat (60) @(negedge clk);
    drain("R5 recall done");
    chk(wr_block == 1'b0, "R2 writes open when idle", wr_block, 0);

    // R2/R3/R4/R1: external request with dirty array
    do_write();
    expect_ev(1, STORE, "R3 external store");
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr_block == 1'b1, "R2 block during grace", wr_block, 1);
    chk(sram_off == 1'b0, "R2 array enabled in grace", sram_off, 0);
    repeat (100) @(negedge clk);
    chk(sram_off == 1'b1 && line_pull == 1'b0, "R4 lock after store", sram_off, 1);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    chk(sram_off == 1'b0 && wr_block == 1'b0, "R4 released on line high", sram_off, 0);
    drain("R3 store seen");

    // R11/R1: dirty cleared by store -> request skipped, still locks
    ext_low = 1'b1;
    repeat (30) @(negedge clk);
    chk(sram_off == 1'b1, "R4 lock after skipped request", sram_off, 1);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    drain("R11 no store after clear");

    // R2: write during grace is refused
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    do_write();
    repeat (30) @(negedge clk);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    drain("R2 blocked write makes no store");

    // R7 clean automatic pulse, R6 brown-out without reset level
    below_sw = 1'b1;
    count_pull(40, cnt);
    chk(cnt == PULSE, "R7 clean pulse length", cnt, PULSE);
    chk(wr_block == 1'b1, "R9 block below switch", wr_block, 1);
    below_sw = 1'b0;
    repeat (60) @(negedge clk);
    drain("R6 no recall after shallow drop");

    // R7 dirty automatic store
    do_write();
    expect_ev(1, STORE, "R7 auto store");
    below_sw = 1'b1;
    count_pull(120, cnt);
    chk(cnt == PULSE + STORE, "R7 pulse plus store", cnt, PULSE + STORE);
    chk(sram_off == 1'b0, "R4 auto store released", sram_off, 0);
    below_sw = 1'b0;
    repeat (5) @(negedge clk);
    drain("R7 auto store seen");

    // R8 abort when line is overdriven high
    do_write();
    ext_high = 1'b1;
    below_sw = 1'b1;
    count_pull(40, cnt);
    chk(cnt > 0 && cnt < PULSE, "R8 pull cut short", cnt, 4);
    below_sw = 1'b0; ext_high = 1'b0;
    repeat (5) @(negedge clk);
    drain("R8 no store after abort");

    // R9: below switch, line request ignored (array still dirty)
    auto_en = 1'b0;
    below_sw = 1'b1;
    repeat (3) @(negedge clk);
    ext_low = 1'b1;
    repeat (40) @(negedge clk);
    chk(sram_off == 1'b0, "R9 request ignored below switch", sram_off, 0);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    below_sw = 1'b0;
    repeat (5) @(negedge clk);
    drain("R9 no store below switch");

    // R10: inhibit mode, dirty array, supply drops
    below_sw = 1'b1;
    count_pull(100, cnt);
    chk(cnt == 0, "R10 no pull in inhibit", cnt, 0);
    below_sw = 1'b0;
    repeat (5) @(negedge clk);
    drain("R10 no store in inhibit");
    auto_en = 1'b1;

    // R11: request during a running store is ignored
    expect_ev(1, STORE, "R11 single store");
    ext_low = 1'b1;
    repeat (30) @(negedge clk);
    below_sw = 1'b1;
    repeat (100) @(negedge clk);
    ext_low = 1'b0;
    repeat (10) @(negedge clk);
    below_sw = 1'b0;
    repeat (5) @(negedge clk);
    drain("R11 only one store");

    // R6/R11: deep brown-out recall clears dirty
    do_write();
    auto_en = 1'b0;
    below_sw = 1'b1; below_rst = 1'b1;
    repeat (5) @(negedge clk);
    below_rst = 1'b0;
    repeat (5) @(negedge clk);
    expect_ev(2, RECALL, "R6 recall after deep drop");
    below_sw = 1'b0;
    repeat (60) @(negedge clk);
    drain("R6 recall seen");
    auto_en = 1'b1;
    ext_low = 1'b1;
    repeat (30) @(negedge clk);
    ext_low = 1'b0;
    repeat (5) @(negedge clk);
    drain("R11 recall clears dirty");

    finish_run();
  end
endmodule